// File: doc/BRIEF.md
# Timed Line Execution Sequencer

This block runs a stream of "lines" that arrive on a valid/ready input. A line carries a 16-bit duration, a shift exponent, six control flags and an opaque data word for the downstream executors. When a line is accepted, the sequencer latches it and issues a one-cycle load strobe. It then keeps the line active for its duration, counted in time units of 2^shift clock cycles. A power-of-two prescaler sets the length of each time unit. The same prescaler produces one evolve-enable pulse per time unit, which paces the executors.

Each line can be gated on an external trigger in two ways. The line's own trigger flag gates it, and so does a hold flag left by the line before it. A trigger counts only while the arm input is high. While a line is active, the sequencer drives silence and aux outputs from the line's flags. It pulses a clear output when a line with the clear flag is accepted, and a jump request in the final cycle of a line with the jump flag. The next line can be accepted in the last cycle of the current one, so that lines follow each other back to back.

Top module: `line_sequencer`

## Requirements
- R1: An accepted line stays active for max(line_dur,1) × 2^line_shift clock cycles, starting in the cycle after acceptance. A duration of zero counts as one time unit.
- R2: While a line is active, evolve_en pulses once at the end of every 2^shift-cycle time unit, so a line produces max(line_dur,1) pulses. evolve_en is low when no line is active.
- R3: A line presented with line_trig=1 is not accepted while trigger is low. It is accepted in a cycle where trigger and arm are both high.
- R4: While arm is low, a trigger is ignored, and a line that needs a trigger is not accepted. A line that needs no trigger is still accepted while arm is low.
- R5: If the most recently accepted line had line_hold=1, the next line waits for a trigger even when its own line_trig=0. The effect applies to one following line only.
- R6: silence equals the active line's silence flag and aux equals its aux flag, for every cycle the line is active. Both are 0 whenever no line is active, including after reset.
- R7: line_ready is high only when no line is active or the active line is in its last cycle (and any trigger gating is satisfied). load_stb is a single-cycle pulse in exactly the cycle of acceptance. Back-to-back lines leave no idle cycle.
- R8: clear_pulse is high for exactly the acceptance cycle of a line with line_clear=1, and never otherwise.
- R9: jump_req pulses once, in the last active cycle of a line with line_jump=1, and never for other lines.
- R10: exec_data takes line_data on acceptance and holds it until the next acceptance, including while idle.
- R11: After reset, line_ready is 1 (no trigger pending), exec_data is 0, and load_stb, evolve_en, silence, aux, jump_req and clear_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 1 | A line is offered on the line_* inputs |
| line_ready | output | 1 | The sequencer can accept the offered line this cycle |
| line_dur | input | DUR_W (16) | Line duration in time units; 0 counts as 1 |
| line_shift | input | SHIFT_W (4) | Time unit is 2^line_shift cycles |
| line_trig | input | 1 | Line must wait for an armed trigger before starting |
| line_hold | input | 1 | The following line must wait for an armed trigger |
| line_silence | input | 1 | Drive silence high while this line is active |
| line_aux | input | 1 | Drive aux high while this line is active |
| line_jump | input | 1 | Request a jump at the end of this line |
| line_clear | input | 1 | Pulse clear_pulse when this line is accepted |
| line_data | input | DATA_W (32) | Opaque executor data |
| trigger | input | 1 | External trigger level |
| arm | input | 1 | Triggers are honoured only while high |
| load_stb | output | 1 | One-cycle strobe: a line is accepted this cycle |
| evolve_en | output | 1 | Executor evolve enable, one pulse per time unit |
| exec_data | output | DATA_W (32) | Data of the most recently accepted line |
| silence | output | 1 | Silence flag of the active line |
| aux | output | 1 | Aux flag of the active line |
| jump_req | output | 1 | Jump request in the last cycle of a jump line |
| clear_pulse | output | 1 | Clear pulse at acceptance of a clear line |

## Verification
The hardest case to reach from the ports is a handover in the exact last cycle of a line: the next line must be accepted in that cycle and must see the hold state of the line that is just ending. To reach it, the stimulus offers the second line while the first is still running. It then counts the cycles to the load strobe, and checks that silence stays high across the boundary. A separate hold-then-plain-then-plain sequence shows that the gate is enforced and also releases after exactly one line. Combined cases of arm low with trigger high show that a trigger level alone never starts a gated line.

// File: rtl/lseq_pkg.sv
package lseq_pkg;

  // Per-line control flags, latched when a line is accepted.
  typedef struct packed {
    logic trig;
    logic hold;
    logic silence;
    logic aux;
    logic jump;
    logic clear;
  } lseq_flags_t;

endpackage

// File: rtl/lseq_prescaler.sv
// Power-of-two prescaler: tick closes every 2^shift cycles while run is high.
module lseq_prescaler #(
  parameter int SHIFT_W = 4,
  parameter int PRE_W   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  // Terminal count for a 2^s cycle unit: s low bits set.
  function automatic logic [PRE_W-1:0] span_of(input logic [SHIFT_W-1:0] s);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] span;

  assign span = span_of(shift);
  assign tick = run && (pre_q == span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (restart)  pre_q <= '0;
    else if (tick)     pre_q <= '0;
    else if (run)      pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/lseq_duration.sv
// Remaining-units counter and active flag for the current line.
module lseq_duration #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DUR_W-1:0] dur_in,
  input  logic             tick,
  output logic             busy,
  output logic             last
);

  // A zero duration still lasts one unit.
  function automatic logic [DUR_W-1:0] eff_units(input logic [DUR_W-1:0] d);
    return (d == '0) ? {{(DUR_W-1){1'b0}}, 1'b1} : d;
  endfunction

  logic [DUR_W-1:0] rem_q;
  logic             busy_q;

  assign busy = busy_q;
  assign last = busy_q && tick && (rem_q == {{(DUR_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      rem_q  <= eff_units(dur_in);
      busy_q <= 1'b1;
    end else begin
      if (busy_q && tick) rem_q <= rem_q - 1'b1;
      if (last)           busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lseq_gate.sv
// Trigger gate: decides whether the offered line may start now.
module lseq_gate (
  input  logic line_trig,
  input  logic hold_pending,
  input  logic trigger,
  input  logic arm,
  output logic start_ok
);

  logic needs_trigger;
  logic armed_trigger;

  assign needs_trigger = line_trig || hold_pending;
  assign armed_trigger = arm && trigger;
  assign start_ok      = !needs_trigger || armed_trigger;

endmodule

// File: rtl/line_sequencer.sv
module line_sequencer #(
  parameter int DUR_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_valid,
  output logic               line_ready,
  input  logic [DUR_W-1:0]   line_dur,
  input  logic [SHIFT_W-1:0] line_shift,
  input  logic               line_trig,
  input  logic               line_hold,
  input  logic               line_silence,
  input  logic               line_aux,
  input  logic               line_jump,
  input  logic               line_clear,
  input  logic [DATA_W-1:0]  line_data,
  input  logic               trigger,
  input  logic               arm,
  output logic               load_stb,
  output logic               evolve_en,
  output logic [DATA_W-1:0]  exec_data,
  output logic               silence,
  output logic               aux,
  output logic               jump_req,
  output logic               clear_pulse
);
  import lseq_pkg::*;

  localparam int PRE_W = (1 << SHIFT_W) - 1;

  // Named internal events, brought out for the checker.
  logic        accept;
  logic        busy;
  logic        done;
  logic        tick;
  logic        start_ok;
  logic        slot_free;

  lseq_flags_t      flags_in;
  lseq_flags_t      flags_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [DATA_W-1:0]  data_q;

  assign flags_in = '{trig:    line_trig,
                      hold:    line_hold,
                      silence: line_silence,
                      aux:     line_aux,
                      jump:    line_jump,
                      clear:   line_clear};

  lseq_gate u_gate (
    .line_trig    (line_trig),
    .hold_pending (flags_q.hold),
    .trigger      (trigger),
    .arm          (arm),
    .start_ok     (start_ok)
  );

  assign slot_free  = !busy || done;
  assign line_ready = slot_free && start_ok;
  assign accept     = line_valid && line_ready;

  lseq_prescaler #(.SHIFT_W(SHIFT_W), .PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy),
    .shift   (shift_q),
    .tick    (tick)
  );

  lseq_duration #(.DUR_W(DUR_W)) u_dur (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .dur_in (line_dur),
    .tick   (tick),
    .busy   (busy),
    .last   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      shift_q <= '0;
      data_q  <= '0;
    end else if (accept) begin
      flags_q <= flags_in;
      shift_q <= line_shift;
      data_q  <= line_data;
    end
  end

  assign load_stb    = accept;
  assign clear_pulse = accept && line_clear;
  assign evolve_en   = tick;
  assign exec_data   = data_q;
  assign silence     = busy && flags_q.silence;
  assign aux         = busy && flags_q.aux;
  assign jump_req    = done && flags_q.jump;

endmodule

// File: rtl/line_sequencer_chk.sv
module line_sequencer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_valid,
  input logic              line_ready,
  input logic              line_trig,
  input logic              trigger,
  input logic              arm,
  input logic              load_stb,
  input logic              evolve_en,
  input logic [DATA_W-1:0] exec_data,
  input logic              silence,
  input logic              aux,
  input logic              jump_req,
  input logic              clear_pulse,
  input logic              busy,
  input logic              done
);

  AST_NO_READY_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> !line_ready); // R7

  AST_LOAD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> line_valid); // R7

  AST_TRIG_LINE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && line_trig) |-> (trigger && arm)); // R3

  AST_NO_TRIG_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && line_trig) |-> !load_stb); // R4

  AST_LOAD_STARTS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> busy); // R1

  AST_EVOLVE_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    evolve_en |-> busy); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!silence && !aux)); // R6

  AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |-> load_stb); // R8

  AST_JUMP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> (done && evolve_en)); // R9

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> $stable(exec_data)); // R10

endmodule

bind line_sequencer line_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_valid  (line_valid),
  .line_ready  (line_ready),
  .line_trig   (line_trig),
  .trigger     (trigger),
  .arm         (arm),
  .load_stb    (load_stb),
  .evolve_en   (evolve_en),
  .exec_data   (exec_data),
  .silence     (silence),
  .aux         (aux),
  .jump_req    (jump_req),
  .clear_pulse (clear_pulse),
  .busy        (busy),
  .done        (done)
);

// File: tb/line_sequencer_tb.sv
module line_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_valid = 1'b0;
  logic        line_ready;
  logic [15:0] line_dur = '0;
  logic [3:0]  line_shift = '0;
  logic        line_trig = 1'b0, line_hold = 1'b0, line_silence = 1'b0;
  logic        line_aux = 1'b0, line_jump = 1'b0, line_clear = 1'b0;
  logic [31:0] line_data = '0;
  logic        trigger = 1'b0, arm = 1'b1;
  logic        load_stb, evolve_en, silence, aux, jump_req, clear_pulse;
  logic [31:0] exec_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  line_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
    .line_dur(line_dur), .line_shift(line_shift), .line_trig(line_trig),
    .line_hold(line_hold), .line_silence(line_silence), .line_aux(line_aux),
    .line_jump(line_jump), .line_clear(line_clear), .line_data(line_data),
    .trigger(trigger), .arm(arm), .load_stb(load_stb), .evolve_en(evolve_en),
    .exec_data(exec_data), .silence(silence), .aux(aux), .jump_req(jump_req),
    .clear_pulse(clear_pulse)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input int dur, input int sh, input bit trg, input bit hld,
                       input bit sil, input bit ax, input bit jmp, input bit clr,
                       input logic [31:0] dat);
    line_dur = 16'(dur); line_shift = 4'(sh);
    line_trig = trg; line_hold = hld; line_silence = sil; line_aux = ax;
    line_jump = jmp; line_clear = clr; line_data = dat; line_valid = 1'b1;
    #1;
  endtask

  // Called at the first negedge after acceptance, with valid already dropped.
  task automatic measure(output int nsil, output int naux, output int nevo,
                         output int njmp, output int jidx);
    int nact = 0;
    nsil = 0; naux = 0; nevo = 0; njmp = 0; jidx = -1;
    for (int k = 0; k < 4000 && (silence || aux); k++) begin
      nact++;
      if (silence) nsil++;
      if (aux) naux++;
      if (evolve_en) nevo++;
      if (jump_req) begin njmp++; jidx = nact; end
      @(negedge clk); #1;
    end
  endtask

  task automatic drop_next;
    @(negedge clk);
    line_valid = 1'b0; trigger = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk(line_ready == 1'b1, "R11 ready", line_ready, 1);
    chk({load_stb, evolve_en, silence, aux, jump_req, clear_pulse} == 6'b0,
        "R11 outputs", {load_stb, evolve_en, silence, aux, jump_req, clear_pulse}, 0);
    chk(exec_data == 32'd0, "R11 exec_data", exec_data, 0);
  endtask

  task automatic t_basic;
    int ns, na, ne, nj, ji;
    @(negedge clk); offer(3, 1, 0, 0, 1, 0, 0, 1, 32'hA5A5_0001);
    chk(load_stb == 1'b1, "R7 load at accept", load_stb, 1);
    chk(clear_pulse == 1'b1, "R8 clear at accept", clear_pulse, 1);
    drop_next;
    chk(load_stb == 1'b0, "R7 load single cycle", load_stb, 0);
    chk(clear_pulse == 1'b0, "R8 clear single cycle", clear_pulse, 0);
    chk(line_ready == 1'b0, "R7 not ready midline", line_ready, 0);
    measure(ns, na, ne, nj, ji);
    chk(ns == 6, "R1 dur3 shift1 cycles", ns, 6);
    chk(ne == 3, "R2 evolve pulses dur3", ne, 3);
    chk(na == 0, "R6 aux low when flag clear", na, 0);
    chk(nj == 0, "R9 no jump for plain line", nj, 0);
    chk(evolve_en == 1'b0, "R2 evolve idle", evolve_en, 0);
    chk(exec_data == 32'hA5A5_0001, "R10 data held idle", exec_data, 32'hA5A5_0001);
  endtask

  task automatic t_zero_aux;
    int ns, na, ne, nj, ji;
    @(negedge clk); offer(0, 2, 0, 0, 0, 1, 0, 0, 32'h0000_0022);
    chk(clear_pulse == 1'b0, "R8 no clear without flag", clear_pulse, 0);
    drop_next;
    measure(ns, na, ne, nj, ji);
    chk(na == 4, "R1 zero duration one unit", na, 4);
    chk(ne == 1, "R2 zero duration one pulse", ne, 1);
    chk(ns == 0, "R6 silence low when flag clear", ns, 0);
    chk(aux == 1'b0, "R6 aux low after line", aux, 0);
  endtask

  task automatic t_shift0;
    int ns, na, ne, nj, ji;
    @(negedge clk); offer(5, 0, 0, 0, 1, 1, 0, 0, 32'h5);
    drop_next;
    chk(evolve_en == 1'b1, "R2 shift0 evolve every cycle", evolve_en, 1);
    measure(ns, na, ne, nj, ji);
    chk(ns == 5 && na == 5, "R6 silence and aux whole line", ns, 5);
    chk(ne == 5, "R2 shift0 pulses", ne, 5);
  endtask

  task automatic t_back_to_back;
    int ns, na, ne, nj, ji, k;
    @(negedge clk); offer(2, 1, 0, 0, 1, 0, 0, 0, 32'h11);
    @(negedge clk); offer(1, 0, 0, 0, 1, 0, 0, 0, 32'h33);
    k = 1;
    for (int i = 0; i < 20 && !load_stb; i++) begin
      @(negedge clk); #1; k++;
    end
    chk(k == 4, "R7 back-to-back load in last cycle", k, 4);
    chk(silence == 1'b1, "R6 first line active at handover", silence, 1);
    drop_next;
    chk(silence == 1'b1, "R7 no idle gap between lines", silence, 1);
    measure(ns, na, ne, nj, ji);
    chk(ns == 1, "R1 second line one cycle", ns, 1);
    chk(exec_data == 32'h33, "R10 data of second line", exec_data, 32'h33);
  endtask

  task automatic t_trigger;
    int ns, na, ne, nj, ji;
    arm = 1'b1; trigger = 1'b0;
    @(negedge clk); offer(1, 0, 1, 0, 1, 0, 0, 0, 32'h44);
    chk(line_ready == 1'b0, "R3 ready low without trigger", line_ready, 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    #1;
    chk(load_stb == 1'b0 && silence == 1'b0, "R3 no start without trigger", load_stb, 0);
    trigger = 1'b1; #1;
    chk(load_stb == 1'b1, "R3 accept on trigger", load_stb, 1);
    drop_next;
    measure(ns, na, ne, nj, ji);
    chk(ns == 1, "R3 triggered line runs", ns, 1);
  endtask

  task automatic t_arm;
    int ns, na, ne, nj, ji;
    arm = 1'b0;
    @(negedge clk); trigger = 1'b1; offer(1, 0, 1, 0, 1, 0, 0, 0, 32'h55);
    chk(load_stb == 1'b0, "R4 trigger ignored disarmed", load_stb, 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    #1;
    chk(silence == 1'b0 && load_stb == 1'b0, "R4 no start disarmed", silence, 0);
    arm = 1'b1; #1;
    chk(load_stb == 1'b1, "R4 accept once armed", load_stb, 1);
    drop_next;
    measure(ns, na, ne, nj, ji);
    arm = 1'b0;
    @(negedge clk); offer(1, 0, 0, 0, 1, 0, 0, 0, 32'h56);
    chk(load_stb == 1'b1, "R4 untriggered line runs disarmed", load_stb, 1);
    drop_next;
    measure(ns, na, ne, nj, ji);
    arm = 1'b1;
  endtask

  task automatic t_hold;
    int ns, na, ne, nj, ji;
    @(negedge clk); offer(1, 0, 0, 1, 1, 0, 0, 0, 32'h66);
    chk(load_stb == 1'b1, "R5 hold line accepted", load_stb, 1);
    drop_next;
    measure(ns, na, ne, nj, ji);
    offer(1, 0, 0, 0, 1, 0, 0, 0, 32'h67);
    chk(load_stb == 1'b0, "R5 next line waits", load_stb, 0);
    @(negedge clk); @(negedge clk); #1;
    chk(load_stb == 1'b0 && silence == 1'b0, "R5 still waiting", load_stb, 0);
    trigger = 1'b1; #1;
    chk(load_stb == 1'b1, "R5 released by trigger", load_stb, 1);
    drop_next;
    measure(ns, na, ne, nj, ji);
    offer(1, 0, 0, 0, 1, 0, 0, 0, 32'h68);
    chk(load_stb == 1'b1, "R5 hold applies to one line only", load_stb, 1);
    drop_next;
    measure(ns, na, ne, nj, ji);
  endtask

  task automatic t_jump;
    int ns, na, ne, nj, ji;
    @(negedge clk); offer(3, 0, 0, 0, 1, 0, 1, 0, 32'h77);
    drop_next;
    measure(ns, na, ne, nj, ji);
    chk(nj == 1, "R9 one jump pulse", nj, 1);
    chk(ji == 3, "R9 jump in last cycle", ji, 3);
    chk(jump_req == 1'b0, "R9 jump low idle", jump_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    t_basic;
    t_zero_aux;
    t_shift0;
    t_back_to_back;
    t_trigger;
    t_arm;
    t_hold;
    t_jump;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule